// File: doc/BRIEF.md
# Decoder Sync Loss Monitor

This block decides whether the symbol stream entering a trellis decoder is phase locked. It watches the decoder's path-metric normalisation pulses. Out of lock, the metrics grow quickly and normalisation fires often. The block counts those pulses over a measurement window, and the window length is counted in valid input symbols. When a window closes, the pulse count is compared with a threshold that can change at runtime. External control lowers that threshold step by step while it searches for lock. A count above the threshold raises the out-of-sync flag. The flag holds its value until the next window closes.

Two operating styles exist. In continuous monitoring, windows run back to back and the block-framing inputs are ignored. In burst monitoring, the input arrives in framed blocks, and each block can come from a different demodulator with its own phase lock. In this style the counters restart at every block start, and a per-block error flag collects any failing window until the block stop strobe. Asking for burst monitoring without enabling block mode is a configuration error, and it is kept in a sticky status bit.

Top module: `sync_loss_monitor`

## Requirements
- R1: The window position advances only on cycles with `symValid` high. A window closes on the valid symbol that brings the number of symbols in it to `windowLen`. A `windowLen` of 0 behaves as 1.
- R2: Every `normPulse` cycle adds one to the normalisation count, including the cycle that closes the window. The count saturates at 2^NORM_W-1 and does not wrap.
- R3: When a window closes, `outOfSync` takes the value (count > `threshold`), using the `threshold` value present in that cycle. The new value is visible after that clock edge. At all other times `outOfSync` holds.
- R4: After a window closes, both counters restart from zero, so each window is judged on its own symbols.
- R5: Burst monitoring is active exactly when `blkModeEn` and `syncByBlk` are both 1. In that state, `blkStart` clears both counters. The symbol and pulse of the start cycle are discarded, and no window closes in that cycle.
- R6: In burst monitoring, `blockErr` sets after any window that closes with count > `threshold`. It stays set until `blkStop`. When `blkStop` and a failing window close fall in the same cycle, `blockErr` ends up clear.
- R7: Whenever burst monitoring is not active, `blockErr` is 0 from the next edge on, and `blkStart` and `blkStop` have no effect on counting.
- R8: `cfgErr` sets on any cycle with `syncByBlk`=1 and `blkModeEn`=0, and stays set. `statusClr` clears it only in a cycle where that condition is absent.
- R9: A synchronous active-high `rst` clears both counters, `outOfSync`, `blockErr` and `cfgErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| symValid | input | 1 | A valid input symbol is present this cycle |
| normPulse | input | 1 | Decoder normalised its path metrics this cycle |
| blkStart | input | 1 | First cycle of an input block |
| blkStop | input | 1 | End-of-block strobe from the decoder output |
| blkModeEn | input | 1 | Block framing enabled |
| syncByBlk | input | 1 | Request burst-dependent monitoring |
| windowLen | input | WIN_W | Window length in valid symbols |
| threshold | input | NORM_W | Highest normalisation count still judged in sync |
| statusClr | input | 1 | Clears the sticky configuration error |
| outOfSync | output | 1 | Verdict of the last closed window |
| blockErr | output | 1 | A window in the current block failed |
| cfgErr | output | 1 | Sticky illegal-configuration status |

## Verification
Two events can collide in one cycle. A block stop can arrive on the same cycle as a failing window close, and a block start can arrive on the very symbol that would close a window. Directed sequences set up a burst with a short window and a zero threshold, then place the stop or start strobe exactly on the closing symbol. The bench judges the result from the flags in the following cycles: `blockErr` must end up clear, and in the start case `outOfSync` must keep its old value because the window was restarted. Random stimulus also produces these coincidences, and a reference model built from the requirements scores every cycle.

// File: rtl/slm_pkg.sv
package slm_pkg;

  // Strobes issued by the control to the counting datapath each cycle
  typedef struct packed {
    logic clrCnt;     // restart both counters (burst block start)
    logic countSym;   // a valid symbol advances the window
    logic countNorm;  // a normalisation pulse is accumulated
    logic endWindow;  // this valid symbol closes the window
  } slmStrobe_t;

  // Combinational status returned by the datapath
  typedef struct packed {
    logic lastSym;    // a counted symbol now would complete the window
    logic overThr;    // count including this cycle exceeds threshold
  } slmStatus_t;

endpackage

// File: rtl/slm_datapath.sv
module slm_datapath
  import slm_pkg::*;
#(
  parameter int WIN_W  = 8,
  parameter int NORM_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  slmStrobe_t        strobe,
  input  logic [WIN_W-1:0]  windowLen,
  input  logic [NORM_W-1:0] threshold,
  output slmStatus_t        status
);

  localparam logic [NORM_W-1:0] NORM_MAX = {NORM_W{1'b1}};

  logic [WIN_W-1:0]  periodCnt;
  logic [NORM_W-1:0] normCnt;
  logic [WIN_W:0]    periodPlusOne;
  logic              normFull;
  logic [NORM_W-1:0] normNext;

  // Position check widened by one bit so a full counter cannot wrap
  assign periodPlusOne  = {1'b0, periodCnt} + (WIN_W+1)'(1);
  assign status.lastSym = periodPlusOne >= {1'b0, windowLen};

  // Saturating accumulation of normalisation events
  assign normFull = (normCnt == NORM_MAX);
  assign normNext = (strobe.countNorm && !normFull) ? normCnt + NORM_W'(1) : normCnt;
  assign status.overThr = normNext > threshold;

  always_ff @(posedge clk) begin
    if (rst || strobe.clrCnt || strobe.endWindow) begin
      periodCnt <= '0;
      normCnt   <= '0;
    end else begin
      if (strobe.countSym) periodCnt <= periodCnt + WIN_W'(1);
      normCnt <= normNext;
    end
  end

  AST_PERIOD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!strobe.countSym && !strobe.clrCnt && !strobe.endWindow) |=> $stable(periodCnt)) // R1
    else $error("period moved without a valid symbol");

  AST_NORM_SAT: assert property (@(posedge clk) disable iff (rst)
    (normCnt == NORM_MAX && !strobe.clrCnt && !strobe.endWindow) |=> (normCnt == NORM_MAX)) // R2
    else $error("normalisation count wrapped");

  AST_WINDOW_RESTART: assert property (@(posedge clk) disable iff (rst)
    strobe.endWindow |=> (periodCnt == '0 && normCnt == '0)) // R4
    else $error("counters not restarted after window");

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
    strobe.clrCnt |=> (periodCnt == '0 && normCnt == '0)) // R5
    else $error("counters not cleared on block start");

endmodule

// File: rtl/slm_ctrl.sv
module slm_ctrl
  import slm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       symValid,
  input  logic       normPulse,
  input  logic       blkStart,
  input  logic       blkStop,
  input  logic       blkModeEn,
  input  logic       syncByBlk,
  input  logic       statusClr,
  input  slmStatus_t status,
  output slmStrobe_t strobe,
  output logic       outOfSync,
  output logic       blockErr,
  output logic       cfgErr
);

  logic burstMode;
  logic badCfg;
  logic failWindow;

  assign burstMode = blkModeEn && syncByBlk;
  assign badCfg    = syncByBlk && !blkModeEn;

  // Block start in burst mode wins over counting for that cycle
  assign strobe.clrCnt    = burstMode && blkStart;
  assign strobe.countSym  = symValid  && !strobe.clrCnt;
  assign strobe.countNorm = normPulse && !strobe.clrCnt;
  assign strobe.endWindow = strobe.countSym && status.lastSym;

  assign failWindow = strobe.endWindow && status.overThr;

  always_ff @(posedge clk) begin
    if (rst) outOfSync <= 1'b0;
    else if (strobe.endWindow) outOfSync <= status.overThr;
  end

  // Per-block error: stop strobe and leaving burst mode take priority
  always_ff @(posedge clk) begin
    if (rst || !burstMode || blkStop) blockErr <= 1'b0;
    else if (failWindow) blockErr <= 1'b1;
  end

  // Sticky configuration error: a present fault wins over the clear
  always_ff @(posedge clk) begin
    if (rst) cfgErr <= 1'b0;
    else if (badCfg) cfgErr <= 1'b1;
    else if (statusClr) cfgErr <= 1'b0;
  end

  AST_VERDICT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.endWindow |=> $stable(outOfSync)) // R3
    else $error("verdict changed between windows");

  AST_BLKERR_SET: assert property (@(posedge clk) disable iff (rst)
    (burstMode && !blkStop && failWindow) |=> blockErr) // R6
    else $error("failing window in block not flagged");

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    blkStop |=> !blockErr) // R6
    else $error("block error survived stop");

  AST_CONT_NO_BLKERR: assert property (@(posedge clk) disable iff (rst)
    !burstMode |=> !blockErr) // R7
    else $error("block error outside burst mode");

  AST_CFG_SET: assert property (@(posedge clk) disable iff (rst)
    badCfg |=> cfgErr) // R8
    else $error("illegal mode not flagged");

  AST_CFG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (cfgErr && !statusClr) |=> cfgErr) // R8
    else $error("config error dropped without clear");

endmodule

// File: rtl/sync_loss_monitor.sv
module sync_loss_monitor
  import slm_pkg::*;
#(
  parameter int WIN_W  = 8,
  parameter int NORM_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              symValid,
  input  logic              normPulse,
  input  logic              blkStart,
  input  logic              blkStop,
  input  logic              blkModeEn,
  input  logic              syncByBlk,
  input  logic [WIN_W-1:0]  windowLen,
  input  logic [NORM_W-1:0] threshold,
  input  logic              statusClr,
  output logic              outOfSync,
  output logic              blockErr,
  output logic              cfgErr
);

  slmStrobe_t strobe;
  slmStatus_t status;

  slm_ctrl uCtrl (
    .clk       (clk),
    .rst       (rst),
    .symValid  (symValid),
    .normPulse (normPulse),
    .blkStart  (blkStart),
    .blkStop   (blkStop),
    .blkModeEn (blkModeEn),
    .syncByBlk (syncByBlk),
    .statusClr (statusClr),
    .status    (status),
    .strobe    (strobe),
    .outOfSync (outOfSync),
    .blockErr  (blockErr),
    .cfgErr    (cfgErr)
  );

  slm_datapath #(.WIN_W(WIN_W), .NORM_W(NORM_W)) uDp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .windowLen (windowLen),
    .threshold (threshold),
    .status    (status)
  );

  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (!outOfSync && !blockErr && !cfgErr)) // R9
    else $error("flags not cleared by reset");

endmodule

// File: tb/tb_sync_loss_monitor.sv
`timescale 1ns/1ps
module tb_sync_loss_monitor;
  localparam int WIN_W  = 8;
  localparam int NORM_W = 6;
  localparam int NMAX   = (1 << NORM_W) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, symValid = 0, normPulse = 0, blkStart = 0, blkStop = 0;
  logic blkModeEn = 0, syncByBlk = 0, statusClr = 0;
  logic [WIN_W-1:0]  windowLen = 8'd4;
  logic [NORM_W-1:0] threshold = 6'd1;
  logic outOfSync, blockErr, cfgErr;

  sync_loss_monitor #(.WIN_W(WIN_W), .NORM_W(NORM_W)) dut (
    .clk(clk), .rst(rst), .symValid(symValid), .normPulse(normPulse),
    .blkStart(blkStart), .blkStop(blkStop), .blkModeEn(blkModeEn),
    .syncByBlk(syncByBlk), .windowLen(windowLen), .threshold(threshold),
    .statusClr(statusClr), .outOfSync(outOfSync), .blockErr(blockErr),
    .cfgErr(cfgErr)
  );

  int total = 0, bad = 0;
  int mPeriod = 0, mNorm = 0;
  logic mOos = 0, mBlk = 0, mCfg = 0;

  function automatic int satInc(int v, logic inc);
    return (inc && v < NMAX) ? v + 1 : v;
  endfunction

  function automatic logic closes(int period, logic [WIN_W-1:0] len);
    return (period + 1) >= int'(len);
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Advance the reference model by one clock using the current inputs
  task automatic modelStep();
    logic burst, clr, cs, cn, endW, over;
    int nn;
    if (rst) begin
      mPeriod = 0; mNorm = 0; mOos = 0; mBlk = 0; mCfg = 0;
      return;
    end
    burst = blkModeEn && syncByBlk;
    clr   = burst && blkStart;
    cs    = symValid && !clr;
    cn    = normPulse && !clr;
    nn    = satInc(mNorm, cn);
    endW  = cs && closes(mPeriod, windowLen);
    over  = nn > int'(threshold);
    if (endW) mOos = over;
    if (!burst || blkStop) mBlk = 0;
    else if (endW && over) mBlk = 1;
    if (syncByBlk && !blkModeEn) mCfg = 1;
    else if (statusClr) mCfg = 0;
    if (clr || endW) begin mPeriod = 0; mNorm = 0; end
    else begin mPeriod = mPeriod + (cs ? 1 : 0); mNorm = nn; end
  endtask

  task automatic cycle(string tag);
    modelStep();
    @(posedge clk);
    #2;
    check({tag, "/R3"}, "outOfSync", outOfSync, mOos);
    check({tag, "/R6"}, "blockErr", blockErr, mBlk);
    check({tag, "/R8"}, "cfgErr", cfgErr, mCfg);
  endtask

  task automatic drive(logic sv, logic np, logic st, logic sp);
    symValid = sv; normPulse = np; blkStart = st; blkStop = sp;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R9: reset state
    drive(0, 0, 0, 0);
    cycle("R9"); cycle("R9");
    check("R9", "outOfSync", outOfSync, 1'b0);
    check("R9", "blockErr", blockErr, 1'b0);
    check("R9", "cfgErr", cfgErr, 1'b0);
    rst = 0;

    // R1: gaps in symValid stretch the window; two pulses > threshold 1
    windowLen = 4; threshold = 1;
    drive(1, 1, 0, 0); cycle("R1");
    drive(0, 1, 0, 0); cycle("R1");
    drive(0, 0, 0, 0); cycle("R1"); cycle("R1");
    drive(1, 0, 0, 0); cycle("R1"); cycle("R1");
    check("R1", "outOfSync early", outOfSync, 1'b0);
    cycle("R1");
    check("R1", "outOfSync at close", outOfSync, 1'b1);

    // R4: next window starts fresh, one pulse is not above 1
    drive(1, 1, 0, 0); cycle("R4");
    drive(1, 0, 0, 0); cycle("R4"); cycle("R4"); cycle("R4");
    check("R4", "outOfSync fresh window", outOfSync, 1'b0);

    // R2: saturation; 200 pulses against threshold NMAX-1 then NMAX
    windowLen = 200; threshold = NMAX - 1;
    for (int i = 0; i < 200; i++) begin drive(1, 1, 0, 0); cycle("R2"); end
    check("R2", "saturated above", outOfSync, 1'b1);
    threshold = NMAX;
    for (int i = 0; i < 200; i++) begin drive(1, 1, 0, 0); cycle("R2"); end
    check("R2", "saturated not above max", outOfSync, 1'b0);

    // R1: windowLen 0 closes on every symbol
    windowLen = 0; threshold = 0;
    drive(1, 1, 0, 0); cycle("R1");
    check("R1", "len0 close", outOfSync, 1'b1);
    drive(1, 0, 0, 0); cycle("R1");
    check("R1", "len0 clean", outOfSync, 1'b0);

    // R7: continuous mode, block strobes ignored, blockErr stays 0
    windowLen = 3; threshold = 0; blkModeEn = 1;
    drive(1, 1, 1, 0); cycle("R7");
    drive(1, 0, 1, 0); cycle("R7");
    drive(1, 0, 0, 1); cycle("R7");
    check("R7", "window ignored start", outOfSync, 1'b1);
    check("R7", "blockErr", blockErr, 1'b0);

    // R6: burst mode, failing window sets blockErr until stop
    syncByBlk = 1; windowLen = 2;
    drive(1, 0, 1, 0); cycle("R5");
    drive(1, 1, 0, 0); cycle("R6");
    drive(1, 0, 0, 0); cycle("R6");
    check("R6", "set", blockErr, 1'b1);
    drive(0, 0, 0, 0); cycle("R6");
    check("R6", "held", blockErr, 1'b1);
    drive(0, 0, 0, 1); cycle("R6");
    check("R6", "cleared", blockErr, 1'b0);

    // R6: stop on the failing close cycle
    drive(1, 1, 1, 0); cycle("R5");
    drive(1, 1, 0, 0); cycle("R6");
    drive(1, 0, 0, 1); cycle("R6");
    check("R6", "stop wins", blockErr, 1'b0);
    check("R6", "verdict still taken", outOfSync, 1'b1);

    // R5: start on the would-be closing symbol restarts the window
    drive(1, 0, 0, 0); cycle("R5");
    drive(1, 0, 0, 0); cycle("R5");
    check("R5", "clean window", outOfSync, 1'b0);
    drive(1, 1, 0, 0); cycle("R5");
    drive(1, 1, 1, 0); cycle("R5");
    check("R5", "no close on start", outOfSync, 1'b0);
    drive(0, 0, 0, 0); cycle("R5");

    // R8: illegal configuration is sticky; clear ignored while present
    blkModeEn = 0;
    cycle("R8");
    check("R8", "set", cfgErr, 1'b1);
    statusClr = 1; cycle("R8");
    check("R8", "clear while bad", cfgErr, 1'b1);
    syncByBlk = 0; statusClr = 0; cycle("R8");
    check("R8", "sticky", cfgErr, 1'b1);
    statusClr = 1; cycle("R8");
    check("R8", "cleared", cfgErr, 1'b0);
    statusClr = 0;

    // Random traffic with periodic mode changes
    for (int i = 0; i < 6000; i++) begin
      if (i % 300 == 0) begin
        case ($urandom % 4)
          0: begin blkModeEn = 0; syncByBlk = 0; end
          1: begin blkModeEn = 1; syncByBlk = 0; end
          2: begin blkModeEn = 1; syncByBlk = 1; end
          default: begin blkModeEn = 0; syncByBlk = 1; end
        endcase
        windowLen = WIN_W'($urandom % 10);
      end
      if ($urandom % 50 == 0) threshold = NORM_W'($urandom % 6);
      statusClr = ($urandom % 40) == 0;
      drive(($urandom % 4) != 0, ($urandom % 3) == 0,
            ($urandom % 12) == 0, ($urandom % 12) == 0);
      rst = ($urandom % 1500) == 0; // R9 mid-run
      cycle("RND");
    end
    rst = 0;

    summary();
    $finish;
  end
endmodule